// File: doc/BRIEF.md
# Strap-Addressed Serial Configuration Slave

This block is the digital control slave of a sensor that shares a serial bus with up to seven identical neighbours. It oversamples a frame-enable line, a serial clock and a serial data line on a fast system clock. Each device is told its bus address by three static strap inputs. The block holds an 8-bit analog trim word made of a 2-bit feedback-capacitance code, a 2-bit integration-time code and a 4-bit post-gain code. It also drives a single enable flag that gates the analog output buffer.

A 2-bit output-control code picks how frames are read. When the code is high, the block takes 8-clock selection frames. Each such frame either enables the analog output of the addressed device or disables it. When the code is low or open, the block takes 16-clock frames that write or read the trim word. A frame opens when the enable line rises and closes when it falls. Every bit is sampled on a rising serial clock, most significant bit first. The bit order is:

1. the direction bit, where 1 means read;
2. the three address bits;
3. four bits that are ignored;
4. the eight trim bits.

Top module: `tws_slave`

## Requirements
- R1: After reset the trim word reads zero on all three field ports, `ser_doe` is 0, and `out_en` is 0 while `oc_level` is 00.
- R2: In a frame taken while `oc_level` is 00 or 01, the write commits when the frame closes only if three conditions hold: exactly 16 rising clocks, direction bit 0, and address bits equal to `strap_addr`. On a commit, frame bits 9..16 load the trim word. `cap_sel` takes bits 9..10, `time_sel` takes bits 11..12 and `gain_sel` takes bits 13..16, each with its most significant bit first.
- R3: A write frame with any clock count other than 16 leaves the trim word unchanged.
- R4: A write frame whose address differs from `strap_addr` leaves the trim word unchanged.
- R5: `out_en` is 0 for `oc_level` 00, is 1 for 01 and for 11, and follows the selection flag for 10.
- R6: While `oc_level` is 10, a frame sets the selection flag when it closes, provided it has exactly 8 rising clocks, direction bit 0 and a matching address. Frames of this kind may follow each other back to back.
- R7: While `oc_level` is 10, the selection flag clears when a frame closes with a wrong address or a clock count other than 8.
- R8: In a read frame with a matching address while `oc_level` is 00 or 01, `ser_doe` rises after the 8th falling serial clock and stays high until the frame closes. After falling clock k, for k from 8 to 15, `ser_dout` carries trim bit 15-k (bit 7 is the MSB). A read with a different address never raises `ser_doe`.
- R9: Read frames, and frames taken while `oc_level` is 10, never change the trim word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_level | input | 2 | Output-control level: 00 low, 01 open, 10 high, 11 treated as open |
| strap_addr | input | 3 | Bus address of this device |
| ser_en | input | 1 | Frame enable line |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data as received from the bus |
| ser_dout | output | 1 | Serial data driven during a read |
| ser_doe | output | 1 | Drive enable for the data pad |
| cap_sel | output | 2 | Feedback-capacitance code |
| time_sel | output | 2 | Integration-time code |
| gain_sel | output | 4 | Post-gain code |
| out_en | output | 1 | Analog output buffer enable |

## Verification
The bench builds the block with its default values: a 3-bit address, 16-clock and 8-clock frames, and two synchroniser stages. It drives serial half periods of six system clocks. At that spacing the synchroniser latency, the falling-edge readout and the close-of-frame commit all fall inside one bit time, so every read bit can be sampled before the next rising clock.

The frames used are:
- off-by-one clock counts on either side of 8 and of 16;
- mismatched addresses in every mode;
- back-to-back selection frames;
- a change of strap address.

A behavioural model of the trim word and the selection flag is compared against the ports on every quiet clock.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    OC_LOW  = 2'b00,
    OC_OPEN = 2'b01,
    OC_HIGH = 2'b10,
    OC_ALT  = 2'b11
  } oc_level_e;

  typedef struct packed {
    logic [1:0] cap;
    logic [1:0] tim;
    logic [3:0] gain;
  } trim_t;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/tws_frame.sv
module tws_frame #(
  parameter int HDR_W = 4,
  parameter int DAT_W = 8,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             se_s,
  input  logic             sck_s,
  input  logic             sd_s,
  output logic             se_d,
  output logic             se_fall,
  output logic             sck_fall,
  output logic [CNT_W-1:0] clk_cnt,
  output logic [HDR_W-1:0] hdr,
  output logic [DAT_W-1:0] shreg
);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);

  logic             sck_d, se_rise, sck_rise;
  logic [CNT_W-1:0] cnt_n;
  logic [HDR_W-1:0] hdr_n;
  logic [DAT_W-1:0] sh_n;

  assign se_rise  = se_s & ~se_d;
  assign se_fall  = ~se_s & se_d;
  assign sck_rise = se_s & sck_s & ~sck_d;
  assign sck_fall = se_s & ~sck_s & sck_d;

  always_comb begin
    cnt_n = clk_cnt;
    hdr_n = hdr;
    sh_n  = shreg;
    if (se_rise) begin
      cnt_n = '0;
      hdr_n = '0;
      sh_n  = '0;
    end else if (sck_rise) begin
      if (clk_cnt != '1) cnt_n = clk_cnt + 1'b1;
      sh_n = {shreg[DAT_W-2:0], sd_s};
      if (clk_cnt == HDR_LAST) hdr_n = {shreg[HDR_W-2:0], sd_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se_d    <= 1'b0;
      sck_d   <= 1'b0;
      clk_cnt <= '0;
      hdr     <= '0;
      shreg   <= '0;
    end else begin
      se_d    <= se_s;
      sck_d   <= sck_s;
      clk_cnt <= cnt_n;
      hdr     <= hdr_n;
      shreg   <= sh_n;
    end
  end
endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int LONG_CLKS   = 16,
  parameter int SHORT_CLKS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        oc_level,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              ser_en,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              ser_doe,
  output logic [1:0]        cap_sel,
  output logic [1:0]        time_sel,
  output logic [3:0]        gain_sel,
  output logic              out_en
);
  localparam int TRIM_W = $bits(trim_t);
  localparam int HDR_W  = ADDR_W + 1;
  localparam int CNT_W  = $clog2(LONG_CLKS + 2);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_CLKS);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_CLKS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [2:0] raw_s;
  tws_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ni), .d({ser_en, ser_clk, ser_din}), .q(raw_s)
  );

  logic              se_d, se_fall, sck_fall;
  logic [CNT_W-1:0]  clk_cnt;
  logic [HDR_W-1:0]  hdr;
  logic [TRIM_W-1:0] shreg;
  tws_frame #(.HDR_W(HDR_W), .DAT_W(TRIM_W), .CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_ni),
    .se_s(raw_s[2]), .sck_s(raw_s[1]), .sd_s(raw_s[0]),
    .se_d(se_d), .se_fall(se_fall), .sck_fall(sck_fall),
    .clk_cnt(clk_cnt), .hdr(hdr), .shreg(shreg)
  );

  logic is_high, hit, rd_dir;
  assign is_high = (oc_level == OC_HIGH);
  assign rd_dir  = hdr[HDR_W-1];
  assign hit     = (hdr[ADDR_W-1:0] == strap_addr);

  trim_t             trim_q, trim_n;
  logic              sel_q, sel_n, oe_q, oe_n, out_q, out_n;
  logic [TRIM_W-1:0] tx_q, tx_n;

  always_comb begin
    trim_n = trim_q;
    sel_n  = sel_q;
    oe_n   = oe_q;
    tx_n   = tx_q;
    if (se_fall) begin
      oe_n = 1'b0;
      if (is_high)
        sel_n = (clk_cnt == SHORT_C) && !rd_dir && hit;
      else if ((clk_cnt == LONG_C) && !rd_dir && hit)
        trim_n = trim_t'(shreg);
    end else if (sck_fall && !is_high) begin
      if (clk_cnt == SHORT_C) begin
        if (rd_dir && hit) begin
          oe_n = 1'b1;
          tx_n = trim_q;
        end
      end else if (oe_q) begin
        tx_n = {tx_q[TRIM_W-2:0], 1'b0};
      end
    end
    case (oc_level)
      OC_LOW:  out_n = 1'b0;
      OC_HIGH: out_n = sel_q;
      default: out_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_q <= '0;
      sel_q  <= 1'b0;
      oe_q   <= 1'b0;
      tx_q   <= '0;
      out_q  <= 1'b0;
    end else begin
      trim_q <= trim_n;
      sel_q  <= sel_n;
      oe_q   <= oe_n;
      tx_q   <= tx_n;
      out_q  <= out_n;
    end
  end

  assign ser_dout = tx_q[TRIM_W-1];
  assign ser_doe  = oe_q;
  assign cap_sel  = trim_q.cap;
  assign time_sel = trim_q.tim;
  assign gain_sel = trim_q.gain;
  assign out_en   = out_q;

  // R3/R4/R9: the trim word moves only on the cycle after a frame closes
  a_r3_trim_moves_at_close: assert property (@(posedge clk) disable iff (!rst_ni)
    (trim_q != $past(trim_q)) |-> $past(se_fall));

  // R6: selection is gained only when a frame closes in high mode
  a_r6_sel_rises_at_close: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(sel_q) |-> $past(se_fall && is_high));

  // R8: the data pad is driven only inside a frame
  a_r8_doe_inside_frame: assert property (@(posedge clk) disable iff (!rst_ni)
    ser_doe |-> se_d);

  // R8: drive starts on a falling serial clock
  a_r8_doe_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ser_doe) |-> $past(sck_fall));

  // R5: low level keeps the analog output off
  a_r5_low_blocks_output: assert property (@(posedge clk) disable iff (!rst_ni)
    (oc_level == OC_LOW) |=> !out_en);
endmodule

// File: tb/tb_tws_slave.sv
module tb_tws_slave;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] oc_level;
  logic [2:0] strap_addr;
  logic       ser_en, ser_clk, ser_din;
  logic       ser_dout, ser_doe;
  logic [1:0] cap_sel, time_sel;
  logic [3:0] gain_sel;
  logic       out_en;

  tws_slave dut (
    .clk(clk), .rst_n(rst_n), .oc_level(oc_level), .strap_addr(strap_addr),
    .ser_en(ser_en), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_dout(ser_dout), .ser_doe(ser_doe),
    .cap_sel(cap_sel), .time_sel(time_sel), .gain_sel(gain_sel),
    .out_en(out_en)
  );

  always #2 clk = ~clk;

  int   n_chk = 0, n_err = 0;
  bit   settled = 0, done = 0;
  logic [7:0] m_trim;
  logic       m_sel;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_out();
    case (oc_level)
      2'b00:   return 1'b0;
      2'b10:   return m_sel;
      default: return 1'b1;
    endcase
  endfunction

  // every quiet clock: model against ports (R2 trim, R5 output, R8 idle pad)
  always @(negedge clk) begin
    if (settled && !done) begin
      chk("R2 trim word", {24'd0, cap_sel, time_sel, gain_sel}, {24'd0, m_trim});
      chk("R5 out_en", {31'd0, out_en}, {31'd0, exp_out()});
      chk("R8 pad idle", {31'd0, ser_doe}, 32'd0);
    end
  end

  task automatic settle();
    repeat (10) @(negedge clk);
    settled = 1;
    @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] bits, input int n,
                       output logic [7:0] rd, output int oe_hi, output int oe_early);
    settled = 0;
    rd = '0; oe_hi = 0; oe_early = 0;
    ser_en = 1'b1;
    repeat (H) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      ser_din = (i < 16) ? bits[15-i] : 1'b0;
      repeat (H) @(negedge clk);
      if (i >= 8 && i <= 15) begin
        rd[15-i] = ser_dout;
        if (ser_doe) oe_hi++;
      end else if (ser_doe) oe_early++;
      ser_clk = 1'b1;
      repeat (H) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (H) @(negedge clk);
    ser_en = 1'b0;
    ser_din = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_oc(input logic [1:0] v);
    settled = 0;
    oc_level = v;
    settle();
  endtask

  function automatic logic [15:0] mk(input logic rw, input logic [2:0] a, input logic [7:0] d);
    return {rw, a, 4'b1010, d};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int hi, early;
    rst_n = 1'b0; oc_level = 2'b00; strap_addr = 3'b101;
    ser_en = 1'b0; ser_clk = 1'b0; ser_din = 1'b0;
    m_trim = 8'h00; m_sel = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk("R1 trim zero", {24'd0, cap_sel, time_sel, gain_sel}, 32'd0);
    chk("R1 out_en low", {31'd0, out_en}, 32'd0);
    chk("R1 doe low", {31'd0, ser_doe}, 32'd0);
    settle();

    // R5 open level
    set_oc(2'b01);
    chk("R5 open enables", {31'd0, out_en}, 32'd1);

    // R2 write with match
    frame(mk(1'b0, 3'b101, 8'hA6), 16, rd, hi, early);
    m_trim = 8'hA6; settle();
    chk("R2 cap field", {30'd0, cap_sel}, 32'd2);
    chk("R2 time field", {30'd0, time_sel}, 32'd2);
    chk("R2 gain field", {28'd0, gain_sel}, 32'd6);

    // R8 read with match; R9 no change
    frame(mk(1'b1, 3'b101, 8'h00), 16, rd, hi, early);
    settle();
    chk("R8 read data", {24'd0, rd}, 32'hA6);
    chk("R8 doe from fall 8", hi, 8);
    chk("R8 doe not before fall 8", early, 0);
    chk("R9 read keeps trim", {24'd0, cap_sel, time_sel, gain_sel}, 32'hA6);

    // R8 read mismatch
    frame(mk(1'b1, 3'b001, 8'h00), 16, rd, hi, early);
    settle();
    chk("R8 mismatch read silent", hi + early, 0);

    // R4 write mismatch
    frame(mk(1'b0, 3'b100, 8'h55), 16, rd, hi, early);
    settle();
    chk("R4 mismatch keeps trim", {24'd0, cap_sel, time_sel, gain_sel}, 32'hA6);

    // R3 wrong counts
    frame(mk(1'b0, 3'b101, 8'h55), 15, rd, hi, early);
    settle();
    chk("R3 15 clocks ignored", {24'd0, cap_sel, time_sel, gain_sel}, 32'hA6);
    frame(mk(1'b0, 3'b101, 8'h55), 17, rd, hi, early);
    settle();
    chk("R3 17 clocks ignored", {24'd0, cap_sel, time_sel, gain_sel}, 32'hA6);

    // R5 low level; R2 write in low level
    set_oc(2'b00);
    chk("R5 low disables", {31'd0, out_en}, 32'd0);
    frame(mk(1'b0, 3'b101, 8'h3C), 16, rd, hi, early);
    m_trim = 8'h3C; settle();
    chk("R2 low-level write", {24'd0, cap_sel, time_sel, gain_sel}, 32'h3C);

    // R2 after strap change
    strap_addr = 3'b010;
    frame(mk(1'b0, 3'b010, 8'hC1), 16, rd, hi, early);
    m_trim = 8'hC1; settle();
    chk("R2 new strap write", {24'd0, cap_sel, time_sel, gain_sel}, 32'hC1);
    strap_addr = 3'b101;

    // R5/R6/R7 high level
    set_oc(2'b10);
    chk("R5 high unselected", {31'd0, out_en}, 32'd0);
    frame(mk(1'b0, 3'b101, 8'h00), 8, rd, hi, early);
    m_sel = 1'b1; settle();
    chk("R6 select", {31'd0, out_en}, 32'd1);
    chk("R9 high frame keeps trim", {24'd0, cap_sel, time_sel, gain_sel}, 32'hC1);
    frame(mk(1'b0, 3'b101, 8'h00), 8, rd, hi, early);
    settle();
    chk("R6 back to back", {31'd0, out_en}, 32'd1);
    frame(mk(1'b0, 3'b011, 8'h00), 8, rd, hi, early);
    m_sel = 1'b0; settle();
    chk("R7 mismatch deselects", {31'd0, out_en}, 32'd0);
    frame(mk(1'b0, 3'b101, 8'h00), 8, rd, hi, early);
    m_sel = 1'b1; settle();
    chk("R6 reselect", {31'd0, out_en}, 32'd1);
    frame(mk(1'b0, 3'b101, 8'h00), 7, rd, hi, early);
    m_sel = 1'b0; settle();
    chk("R7 7 clocks deselects", {31'd0, out_en}, 32'd0);
    frame(mk(1'b0, 3'b101, 8'h00), 8, rd, hi, early);
    m_sel = 1'b1; settle();
    frame(mk(1'b0, 3'b101, 8'h00), 9, rd, hi, early);
    m_sel = 1'b0; settle();
    chk("R7 9 clocks deselects", {31'd0, out_en}, 32'd0);
    frame(mk(1'b0, 3'b101, 8'h00), 8, rd, hi, early);
    m_sel = 1'b1; settle();
    frame(mk(1'b0, 3'b101, 8'h77), 16, rd, hi, early);
    m_sel = 1'b0; settle();
    chk("R7 long frame deselects", {31'd0, out_en}, 32'd0);
    chk("R9 long frame in high keeps trim", {24'd0, cap_sel, time_sel, gain_sel}, 32'hC1);

    // R5 code 11 acts as open
    set_oc(2'b11);
    chk("R5 code 11 enables", {31'd0, out_en}, 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule